// File: doc/BRIEF.md
# Cipher Accelerator Event and Interrupt Controller

This block gathers the event pulses of a cipher accelerator and turns them into latched status flags, an enable mask and one level-sensitive interrupt line. Five sources are tracked: input transfer complete (bit 0), result ready (bit 1), transfer bus fault (bit 2), key-store write fault (bit 3) and key-store read fault (bit 4). A one-cycle pulse on a source input sets its flag. The flag then stays set until software writes a one to that bit of the clear register.

Software reaches the block through a word-addressed register port with eight locations. The enable register can be loaded whole, or updated bit by bit through separate set and clear locations. The status can be read raw, ANDed with the enable register, or ANDed with a mask held in a wait-mask register. Software that polls for completion uses the last of these. Only the two completion flags can ever drive the interrupt line. The three fault flags show only in the status views, even when their enable bits are set.

Top module: `crypto_irq_ctrl`

## Requirements
- R1: After a synchronous reset, every status flag, the enable register and the wait mask are zero, and `irq_o` is low.
- R2: A high level on `evt_i[k]` at a clock edge sets flag k at that edge. The flag stays set over any number of idle cycles until it is cleared.
- R3: A write to address 3 clears every flag whose data bit is one. Flags whose data bit is zero keep their value.
- R4: When an event and a clear reach the same flag at the same edge, the flag ends set.
- R5: A write to address 1 loads the enable register from data bits 4:0. A read of address 1 returns it, with bits above 4 reading as zero.
- R6: A write to address 4 sets the enable bits where the data is one. A write to address 5 clears the enable bits where the data is one. Other enable bits are unchanged.
- R7: A read of address 2 returns the enable register ANDed with the flags.
- R8: `irq_o` is high one cycle after (flags AND enable AND 5'b00011) becomes nonzero, and low one cycle after it becomes zero. Flags 2 to 4 never raise it.
- R9: A read of address 0 returns all five flags in bits 4:0 and zero above.
- R10: Address 6 holds a readable wait mask. A read of address 7 returns the flags ANDed with that mask, so the result is nonzero only while a masked flag is set.
- R11: Read data and `rd_valid_o` appear on the cycle after `rd_en_i`. Reads of addresses 3, 4 and 5 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 5 | Event pulses, one per source |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 3 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| rd_valid_o | output | 1 | Read data valid, one cycle after the strobe |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench builds the block with its default parameters: five sources, a 32-bit data path and an interrupt-capable mask of 5'b00011. With these values, enabled fault flags can be shown to stay off the line while still appearing in the raw, masked and wait views. The 32-bit width also lets the bench write all-ones patterns and confirm that bits above the source count read back as zero. One step drives an event and a clear into the same flag at the same edge to show that the event wins.

// File: rtl/crypto_irq_pkg.sv
package crypto_irq_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_RAW       = 3'd0,
    REG_ENABLE    = 3'd1,
    REG_MASKED    = 3'd2,
    REG_CLEAR     = 3'd3,
    REG_EN_SET    = 3'd4,
    REG_EN_CLR    = 3'd5,
    REG_WAIT_MASK = 3'd6,
    REG_WAIT_STAT = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/crypto_irq_flags.sv
module crypto_irq_flags #(
  parameter int NUM_SRC = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] evt,
  input  logic [NUM_SRC-1:0] clr,
  output logic [NUM_SRC-1:0] raw_q
);
  for (genvar k = 0; k < NUM_SRC; k++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)         raw_q[k] <= 1'b0;
      else if (evt[k]) raw_q[k] <= 1'b1;
      else if (clr[k]) raw_q[k] <= 1'b0;
    end

    // R2
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (raw_q[k] && !clr[k]) |=> raw_q[k]);
    // R4
    event_wins_chk: assert property (@(posedge clk) disable iff (rst)
      evt[k] |=> raw_q[k]);
    // R3
    clear_drop_chk: assert property (@(posedge clk) disable iff (rst)
      (clr[k] && !evt[k]) |=> !raw_q[k]);
  end
endmodule

// File: rtl/crypto_irq_enable.sv
module crypto_irq_enable #(
  parameter int NUM_SRC = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic               set,
  input  logic               clr,
  input  logic [NUM_SRC-1:0] bits,
  output logic [NUM_SRC-1:0] en_q
);
  always_ff @(posedge clk) begin
    if (rst)       en_q <= '0;
    else if (load) en_q <= bits;
    else if (set)  en_q <= en_q | bits;
    else if (clr)  en_q <= en_q & ~bits;
  end

  // R6
  en_set_chk: assert property (@(posedge clk) disable iff (rst)
    set |=> ((en_q & $past(bits)) == $past(bits)));
  // R6
  en_clr_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> ((en_q & $past(bits)) == '0));
  // R6
  en_keep_chk: assert property (@(posedge clk) disable iff (rst)
    !(load || set || clr) |=> $stable(en_q));
endmodule

// File: rtl/crypto_irq_regbank.sv
module crypto_irq_regbank
  import crypto_irq_pkg::*;
#(
  parameter int NUM_SRC = 5,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [NUM_SRC-1:0] raw,
  input  logic [NUM_SRC-1:0] en,
  output logic [NUM_SRC-1:0] clr_bits,
  output logic               en_load,
  output logic               en_set,
  output logic               en_clr,
  output logic [NUM_SRC-1:0] wbits,
  output logic [DATA_W-1:0]  rdata,
  output logic               rvalid
);
  reg_sel_e           sel;
  logic [NUM_SRC-1:0] wait_mask_q;
  logic [NUM_SRC-1:0] rd_mux;
  logic               unused_wdata_hi;

  assign sel             = reg_sel_e'(addr);
  assign wbits           = wdata[NUM_SRC-1:0];
  assign unused_wdata_hi = ^wdata[DATA_W-1:NUM_SRC];

  assign clr_bits = (wr_en && sel == REG_CLEAR) ? wbits : '0;
  assign en_load  = wr_en && (sel == REG_ENABLE);
  assign en_set   = wr_en && (sel == REG_EN_SET);
  assign en_clr   = wr_en && (sel == REG_EN_CLR);

  always_ff @(posedge clk) begin
    if (rst)                                 wait_mask_q <= '0;
    else if (wr_en && sel == REG_WAIT_MASK)  wait_mask_q <= wbits;
  end

  always_comb begin
    unique case (sel)
      REG_RAW:       rd_mux = raw;
      REG_ENABLE:    rd_mux = en;
      REG_MASKED:    rd_mux = raw & en;
      REG_WAIT_MASK: rd_mux = wait_mask_q;
      REG_WAIT_STAT: rd_mux = raw & wait_mask_q;
      default:       rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) rdata <= DATA_W'(rd_mux);
    end
  end

  // R11
  rvalid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rvalid);
  // R11
  wo_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (sel == REG_CLEAR || sel == REG_EN_SET || sel == REG_EN_CLR))
      |=> (rdata == '0));
  // R9
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rvalid |-> (rdata[DATA_W-1:NUM_SRC] == '0));
endmodule

// File: rtl/crypto_irq_ctrl.sv
module crypto_irq_ctrl
  import crypto_irq_pkg::*;
#(
  parameter int                 NUM_SRC     = 5,
  parameter int                 DATA_W      = 32,
  parameter logic [NUM_SRC-1:0] IRQ_CAPABLE = 5'b00011
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               rd_valid_o,
  output logic               irq_o
);
  logic [NUM_SRC-1:0] raw_q;
  logic [NUM_SRC-1:0] en_q;
  logic [NUM_SRC-1:0] clr_bits;
  logic [NUM_SRC-1:0] wbits;
  logic               en_load, en_set, en_clr;
  logic [NUM_SRC-1:0] pending;

  crypto_irq_flags #(.NUM_SRC(NUM_SRC)) u_flags (
    .clk(clk), .rst(rst), .evt(evt_i), .clr(clr_bits), .raw_q(raw_q)
  );

  crypto_irq_enable #(.NUM_SRC(NUM_SRC)) u_enable (
    .clk(clk), .rst(rst), .load(en_load), .set(en_set), .clr(en_clr),
    .bits(wbits), .en_q(en_q)
  );

  crypto_irq_regbank #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en_i), .rd_en(rd_en_i), .addr(addr_i),
    .wdata(wdata_i), .raw(raw_q), .en(en_q), .clr_bits(clr_bits),
    .en_load(en_load), .en_set(en_set), .en_clr(en_clr), .wbits(wbits),
    .rdata(rdata_o), .rvalid(rd_valid_o)
  );

  assign pending = raw_q & en_q & IRQ_CAPABLE;

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= |pending;
  end

  // R8
  irq_level_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o == $past(|(raw_q & en_q & IRQ_CAPABLE)));
  // R8
  fault_silent_chk: assert property (@(posedge clk) disable iff (rst)
    ((raw_q & en_q & IRQ_CAPABLE) == '0) |=> !irq_o);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!irq_o && raw_q == '0 && en_q == '0));
endmodule

// File: tb/test_crypto_irq_ctrl.sv
module test_crypto_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  evt = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rd_valid, irq;

  int checks = 0, failures = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  crypto_irq_ctrl i_crypto_irq_ctrl (
    .clk(clk), .rst(rst), .evt_i(evt), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .rd_valid_o(rd_valid),
    .irq_o(irq)
  );

  // monitor: pops the expected read values as the design returns them
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL unexpected read data: actual %h expected none", rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rdata !== e) begin
          failures++;
          $display("FAIL %s: actual %h expected %h", t, rdata, e);
        end
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_wr(logic [2:0] a, logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic reg_rd(logic [2:0] a, logic [31:0] e, string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic pulse(logic [4:0] m);
    evt = m;
    @(negedge clk);
    evt = '0;
  endtask

  task automatic chk_irq(logic e, string t);
    checks++;
    if (irq !== e) begin
      failures++;
      $display("FAIL %s: actual irq %b expected %b", t, irq, e);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    evt = 5'b11111;
    idle(3);
    evt = '0;
    rst = 1'b0;
    chk_irq(1'b0, "R1 irq after reset");
    reg_rd(3'd0, 32'h0, "R1 raw after reset");
    reg_rd(3'd1, 32'h0, "R1 enable after reset");
    reg_rd(3'd6, 32'h0, "R1 wait mask after reset");

    pulse(5'b00001);
    idle(1);
    chk_irq(1'b0, "R8 disabled source quiet");
    reg_rd(3'd0, 32'h1, "R2 flag set by event");

    reg_wr(3'd1, 32'h3);
    reg_rd(3'd1, 32'h3, "R5 enable readback");
    chk_irq(1'b1, "R8 irq after enable");
    reg_rd(3'd2, 32'h1, "R7 masked view");

    reg_wr(3'd3, 32'h1);
    idle(1);
    chk_irq(1'b0, "R3 irq drops after clear");
    reg_rd(3'd0, 32'h0, "R3 flag cleared");

    pulse(5'b11100);
    reg_wr(3'd1, 32'hFFFF_FFFF);
    reg_rd(3'd1, 32'h1F, "R5 enable upper bits zero");
    idle(1);
    chk_irq(1'b0, "R8 enabled faults stay off the line");
    reg_rd(3'd0, 32'h1C, "R9 raw shows fault flags");
    reg_rd(3'd2, 32'h1C, "R7 masked shows enabled faults");

    reg_wr(3'd5, 32'h1C);
    reg_rd(3'd1, 32'h03, "R6 enable clear by ones");
    reg_wr(3'd4, 32'h04);
    reg_rd(3'd1, 32'h07, "R6 enable set by ones");
    reg_rd(3'd2, 32'h04, "R7 masked after set");

    // event and clear on the same edge for bit 1
    evt = 5'b00010; wr_en = 1'b1; addr = 3'd3; wdata = 32'h1E;
    @(negedge clk);
    evt = '0; wr_en = 1'b0; wdata = '0;
    reg_rd(3'd0, 32'h02, "R4 event beats clear");
    chk_irq(1'b1, "R4 irq from surviving flag");

    reg_wr(3'd6, 32'h01);
    reg_rd(3'd7, 32'h00, "R10 wait status before event");
    reg_rd(3'd6, 32'h01, "R10 wait mask readback");
    pulse(5'b00001);
    reg_rd(3'd7, 32'h01, "R10 wait status after event");
    reg_wr(3'd6, 32'h1C);
    reg_rd(3'd7, 32'h00, "R10 wait status masked off");

    reg_rd(3'd3, 32'h0, "R11 clear location reads zero");
    reg_rd(3'd4, 32'h0, "R11 set location reads zero");
    idle(5);
    reg_rd(3'd0, 32'h03, "R2 flags held while idle");

    reg_wr(3'd3, 32'h01);
    reg_rd(3'd0, 32'h02, "R3 zero bits untouched");
    reg_wr(3'd3, 32'h1F);
    idle(1);
    chk_irq(1'b0, "R8 irq low after full clear");
    reg_rd(3'd0, 32'h00, "R3 all flags cleared");

    idle(3);
    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL R11 reads not answered: actual %0d pending expected 0", exp_q.size());
    end
    finish_run();
  end

  initial begin
    #(20 * 100000);
    checks++;
    failures++;
    $display("FAIL watchdog expired: actual hung expected finished");
    finish_run();
  end
endmodule